// File: doc/BRIEF.md
# Self-Polling Command Ring Fetcher

This engine sits on the device side of a host link. It pulls read commands out of a ring of 64-byte entries in host memory without waiting for the host to announce them. The engine keeps asking for the next ring slot on its own. It compares a phase bit in each returned entry with the phase it expects, and passes new entries through a small command queue to a parser. An empty answer only costs another request.

A progress count from the data-send path holds each request back until the current transfer is close enough to its end. The margin is the programmed round-trip time, so a new command lands just as the device can take it. A sliding window of recent fetch results measures the load. When fewer new commands than a threshold are seen, the engine stops polling and waits for a doorbell pulse. It then drains the ring and goes quiet again on the first empty slot. When the load climbs back to the threshold, polling resumes.

Top module: `cmd_ring_fetcher`

## Requirements
- R1: While reset is held, neither `req_valid` nor `cmd_valid` is asserted.
- R2: In polling mode, requests are raised with no doorbell. Each request carries address `cfg_base + slot*64` and length 64, and the first slot after reset is 0.
- R3: No more than `MAX_OUT` requests are ever outstanding (issued but not answered).
- R4: A returned entry is new only when bit 511 equals the expected phase, which is 1 after reset. A new entry goes to the command output and advances the head. An entry that is not new is dropped, and fetching restarts at the head slot.
- R5: The ring holds `2**cfg_ring_lg2` slots. The expected phase inverts each time the head wraps from the last slot back to slot 0.
- R6: Completions return in request order. When a completion is not new, the answers to requests already issued beyond it are discarded, even if they hold new entries. Those slots are fetched again after the head slot.
- R7: No request is raised while the outstanding requests plus the stored commands fill the command queue (`FIFO_DEPTH`).
- R8: A request is raised only while `xfer_left <= cfg_rtt`, where `xfer_left` is the number of cycles the data path still needs for the current transfer.
- R9: When the count of new results in the last `WIN` answered fetches is below `cfg_thresh`, requests need a pending doorbell. A `doorbell` pulse allows one fetch. Each new entry returned in this mode allows one more, and an empty one ends the run.
- R10: When the load count reaches `cfg_thresh`, polling resumes without doorbells. Polling stops again once old results leave the window and the count falls below the threshold.
- R11: Commands leave in ring order with their contents unchanged. A command held by `cmd_ready` low stays valid and stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | ADDR_W | Host address of ring slot 0 |
| cfg_ring_lg2 | input | LG2_W | log2 of ring slot count (1..IDX_W) |
| cfg_rtt | input | TIME_W | Round-trip lead time in cycles |
| cfg_thresh | input | LOAD_W | Load threshold for polling |
| doorbell | input | 1 | Host notice of new commands (used below threshold) |
| xfer_left | input | TIME_W | Cycles left in the current data transfer, 0 when idle |
| req_valid | output | 1 | Fetch request present |
| req_ready | input | 1 | Transaction layer takes the request |
| req_addr | output | ADDR_W | Fetch address |
| req_len | output | LEN_W | Fetch length in bytes (64) |
| cpl_valid | input | 1 | Completion entry present |
| cpl_data | input | 512 | Returned ring entry, phase in bit 511 |
| cmd_valid | output | 1 | Command available for the parser |
| cmd_ready | input | 1 | Parser takes the command |
| cmd_data | output | 512 | Command entry |

## Verification
The embedded checks rely on the transaction layer answering requests in the order they were issued, and never sending a completion when nothing is outstanding. They also assume the ring size and base stay fixed between resets. The bench host model keeps every request in an ordered list and answers only from its front after a fixed latency. It changes configuration only while reset is held. Ring contents are written at falling edges, so each answer reflects one consistent snapshot of host memory.

// File: rtl/cqf_pkg.sv
package cqf_pkg;
   localparam int unsigned ENTRY_BYTES = 64;
   localparam int unsigned ENTRY_W     = ENTRY_BYTES * 8;
   localparam int unsigned ENTRY_SH    = $clog2(ENTRY_BYTES);

   typedef enum logic {
      MODE_DOORBELL = 1'b0,
      MODE_POLL     = 1'b1
   } fetch_mode_e;
endpackage

// File: rtl/cqf_ring_track.sv
module cqf_ring_track #(
   parameter int unsigned IDX_W = 4,
   parameter int unsigned LG2_W = $clog2(IDX_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LG2_W-1:0] cfg_lg2,
   input  logic             issue,
   input  logic             accept,
   input  logic             rewind,
   output logic [IDX_W-1:0] head_idx,
   output logic [IDX_W-1:0] fetch_idx,
   output logic             exp_phase
);
   logic [IDX_W-1:0] ring_mask;
   logic [IDX_W-1:0] head_inc;
   logic [IDX_W-1:0] fetch_inc;
   logic             head_wrap;

   assign ring_mask = ~({IDX_W{1'b1}} << cfg_lg2);
   assign head_wrap = (head_idx == ring_mask);
   assign head_inc  = head_wrap ? '0 : head_idx + IDX_W'(1);
   assign fetch_inc = (fetch_idx + IDX_W'(1)) & ring_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_idx  <= '0;
         fetch_idx <= '0;
         exp_phase <= 1'b1;
      end else begin
         if (accept) begin
            head_idx <= head_inc;
            if (head_wrap) exp_phase <= ~exp_phase;
         end
         if (rewind)     fetch_idx <= head_idx;
         else if (issue) fetch_idx <= fetch_inc;
      end
   end

   // R5: leaving the last slot lands on slot 0 with the opposite phase
   p_phase_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && head_wrap) |=> (head_idx == '0) && (exp_phase != $past(exp_phase)));

   // R6: after a miss the next fetch targets the head slot
   p_rewind_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rewind && !accept) |=> (fetch_idx == head_idx));
endmodule

// File: rtl/cqf_cmd_fifo.sv
module cqf_cmd_fifo #(
   parameter int unsigned W     = 512,
   parameter int unsigned DEPTH = 4,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     push_data,
   input  logic             pop_ready,
   output logic             out_valid,
   output logic [W-1:0]     out_data,
   output logic [CNT_W-1:0] count
);
   localparam int unsigned PTR_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cqf_cmd_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0]     store [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic             pop;
   logic             full;

   assign out_valid = (count != '0);
   assign out_data  = store[rd_ptr];
   assign pop       = out_valid && pop_ready;
   assign full      = (count == CNT_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) begin
            store[wr_ptr] <= push_data;
            wr_ptr        <= wr_ptr + PTR_W'(1);
         end
         if (pop) rd_ptr <= rd_ptr + PTR_W'(1);
         count <= count + CNT_W'(push) - CNT_W'(pop);
      end
   end

   // R7: the issue gate reserves room for every answer in flight
   p_push_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R11: a stalled command keeps its value
   p_hold_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !pop_ready) |=> out_valid && $stable(out_data));
endmodule

// File: rtl/cqf_load_mon.sv
module cqf_load_mon
   import cqf_pkg::*;
#(
   parameter int unsigned WIN    = 8,
   parameter int unsigned LOAD_W = $clog2(WIN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic              hit,
   input  logic [LOAD_W-1:0] thresh,
   output fetch_mode_e       mode
);
   logic [LOAD_W-1:0] load_cnt;

   if (WIN == 1) begin : g_single
      logic win_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      win_q <= 1'b0;
         else if (sample) win_q <= hit;
      end
      assign load_cnt = LOAD_W'(win_q);
   end else begin : g_shift
      logic [WIN-1:0] win_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      win_q <= '0;
         else if (sample) win_q <= {win_q[WIN-2:0], hit};
      end
      assign load_cnt = LOAD_W'($countones(win_q));
   end

   assign mode = (load_cnt >= thresh) ? MODE_POLL : MODE_DOORBELL;

   // R10: the load figure moves only when a fetch result is recorded
   p_load_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !sample |=> $stable(load_cnt));
endmodule

// File: rtl/cmd_ring_fetcher.sv
module cmd_ring_fetcher
   import cqf_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned IDX_W      = 4,
   parameter int unsigned MAX_OUT    = 2,
   parameter int unsigned FIFO_DEPTH = 4,
   parameter int unsigned WIN        = 8,
   parameter int unsigned TIME_W     = 8,
   parameter int unsigned LG2_W      = $clog2(IDX_W + 1),
   parameter int unsigned LOAD_W     = $clog2(WIN + 1),
   parameter int unsigned LEN_W      = $clog2(ENTRY_BYTES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  cfg_base,
   input  logic [LG2_W-1:0]   cfg_ring_lg2,
   input  logic [TIME_W-1:0]  cfg_rtt,
   input  logic [LOAD_W-1:0]  cfg_thresh,
   input  logic               doorbell,
   input  logic [TIME_W-1:0]  xfer_left,
   output logic               req_valid,
   input  logic               req_ready,
   output logic [ADDR_W-1:0]  req_addr,
   output logic [LEN_W-1:0]   req_len,
   input  logic               cpl_valid,
   input  logic [ENTRY_W-1:0] cpl_data,
   output logic               cmd_valid,
   input  logic               cmd_ready,
   output logic [ENTRY_W-1:0] cmd_data
);
   localparam int unsigned OUT_W   = $clog2(MAX_OUT + 1);
   localparam int unsigned FCNT_W  = $clog2(FIFO_DEPTH + 1);
   localparam int unsigned SUM_W   = $clog2(MAX_OUT + FIFO_DEPTH + 1);
   localparam int unsigned PHASE_B = ENTRY_W - 1;

   if (MAX_OUT < 1 || MAX_OUT > FIFO_DEPTH) begin : g_bad_out
      $error("cmd_ring_fetcher: MAX_OUT must be in 1..FIFO_DEPTH");
   end
   if (IDX_W + ENTRY_SH > ADDR_W) begin : g_bad_addr
      $error("cmd_ring_fetcher: ring span exceeds address width");
   end

   logic              armed;
   logic [OUT_W-1:0]  out_cnt;
   logic [OUT_W-1:0]  squash_cnt;
   logic              db_pend;
   logic [FCNT_W-1:0] fifo_cnt;
   logic [SUM_W-1:0]  committed;
   logic [IDX_W-1:0]  head_idx;
   logic [IDX_W-1:0]  fetch_idx;
   logic              exp_phase;
   fetch_mode_e       mode;
   logic              fire;
   logic              cpl_live;
   logic              cpl_stale;
   logic              accept;
   logic              miss;

   assign committed = SUM_W'(out_cnt) + SUM_W'(fifo_cnt);
   assign req_valid = armed
                   && (out_cnt < OUT_W'(MAX_OUT))
                   && (committed < SUM_W'(FIFO_DEPTH))
                   && (xfer_left <= cfg_rtt)
                   && ((mode == MODE_POLL) || db_pend);
   assign fire      = req_valid && req_ready;
   assign req_addr  = cfg_base + (ADDR_W'(fetch_idx) << ENTRY_SH);
   assign req_len   = LEN_W'(ENTRY_BYTES);

   assign cpl_live  = cpl_valid && (squash_cnt == '0);
   assign cpl_stale = cpl_valid && (squash_cnt != '0);
   assign accept    = cpl_live && (cpl_data[PHASE_B] == exp_phase);
   assign miss      = cpl_live && (cpl_data[PHASE_B] != exp_phase);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         out_cnt    <= '0;
         squash_cnt <= '0;
         db_pend    <= 1'b0;
      end else begin
         armed   <= 1'b1;
         out_cnt <= out_cnt + OUT_W'(fire) - OUT_W'(cpl_valid);
         if (miss)           squash_cnt <= out_cnt - OUT_W'(1) + OUT_W'(fire);
         else if (cpl_stale) squash_cnt <= squash_cnt - OUT_W'(1);
         if (doorbell || (accept && mode == MODE_DOORBELL)) db_pend <= 1'b1;
         else if (fire)                                     db_pend <= 1'b0;
      end
   end

   cqf_ring_track #(.IDX_W(IDX_W), .LG2_W(LG2_W)) ring_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_lg2   (cfg_ring_lg2),
      .issue     (fire),
      .accept    (accept),
      .rewind    (miss),
      .head_idx  (head_idx),
      .fetch_idx (fetch_idx),
      .exp_phase (exp_phase)
   );

   cqf_load_mon #(.WIN(WIN), .LOAD_W(LOAD_W)) load_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .sample (cpl_live),
      .hit    (accept),
      .thresh (cfg_thresh),
      .mode   (mode)
   );

   cqf_cmd_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH), .CNT_W(FCNT_W)) fifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (accept),
      .push_data (cpl_data),
      .pop_ready (cmd_ready),
      .out_valid (cmd_valid),
      .out_data  (cmd_data),
      .count     (fifo_cnt)
   );

   // R3: outstanding fetches stay within the cap
   p_out_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_cnt <= OUT_W'(MAX_OUT));

   // R8: a request only appears inside the lead window
   p_lead_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (xfer_left <= cfg_rtt));

   // R9: below the threshold nothing leaves without a doorbell credit
   p_db_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_DOORBELL && !db_pend) |-> !req_valid);

   // R6: answers only come for requests in flight; discards never exceed them
   p_cpl_owed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid |-> (out_cnt != '0));
   p_squash_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      squash_cnt <= out_cnt);
endmodule

// File: tb/cmd_ring_fetcher_tb_top.sv
module cmd_ring_fetcher_tb_top;
   localparam int unsigned ADDR_W = 32;
   localparam int unsigned IDX_W  = 4;
   localparam int unsigned TIME_W = 8;
   localparam int unsigned LOAD_W = 4;
   localparam logic [31:0] BASE   = 32'h0004_1000;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [ADDR_W-1:0]  cfg_base = BASE;
   logic [2:0]         cfg_ring_lg2 = 3'd2;
   logic [TIME_W-1:0]  cfg_rtt = '0;
   logic [LOAD_W-1:0]  cfg_thresh = '0;
   logic               doorbell = 1'b0;
   logic [TIME_W-1:0]  xfer_left = '0;
   logic               req_valid;
   logic               req_ready = 1'b1;
   logic [ADDR_W-1:0]  req_addr;
   logic [6:0]         req_len;
   logic               cpl_valid;
   logic [511:0]       cpl_data;
   logic               cmd_valid;
   logic               cmd_ready = 1'b1;
   logic [511:0]       cmd_data;

   always #2.5 clk = ~clk;

   cmd_ring_fetcher dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_ring_lg2(cfg_ring_lg2),
      .cfg_rtt(cfg_rtt), .cfg_thresh(cfg_thresh), .doorbell(doorbell),
      .xfer_left(xfer_left), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .cpl_valid(cpl_valid),
      .cpl_data(cpl_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_data(cmd_data)
   );

   // host model
   logic [511:0] host_mem [16];
   logic         resp_en = 1'b1;
   int           resp_lat = 4;
   int           cyc = 0;
   int           fires = 0;
   int           len_bad = 0;
   int           rq_idx [$];
   int           rq_t [$];
   logic [31:0]  addr_log [$];
   logic [31:0]  got [$];

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (!rst_n) begin
         rq_idx.delete(); rq_t.delete(); addr_log.delete(); got.delete();
         fires = 0; len_bad = 0;
         cpl_valid <= 1'b0;
         cpl_data  <= '0;
      end else begin
         if (req_valid && req_ready) begin
            rq_idx.push_back(int'((req_addr - BASE) >> 6) & 15);
            rq_t.push_back(cyc);
            addr_log.push_back(req_addr);
            fires = fires + 1;
            if (req_len != 7'd64) len_bad = len_bad + 1;
         end
         if (resp_en && rq_idx.size() > 0 && (cyc - rq_t[0]) >= resp_lat) begin
            cpl_valid <= 1'b1;
            cpl_data  <= host_mem[rq_idx[0]];
            void'(rq_idx.pop_front());
            void'(rq_t.pop_front());
         end else begin
            cpl_valid <= 1'b0;
         end
         if (cmd_valid && cmd_ready) got.push_back(cmd_data[31:0]);
      end
   end

   int  n_chk = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put_entry(input int idx, input bit ph, input logic [31:0] tag);
      host_mem[idx] = {ph, 479'd0, tag};
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic [2:0] lg2, input logic [LOAD_W-1:0] th,
                           input logic [TIME_W-1:0] rtt, input logic [TIME_W-1:0] xl);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_ring_lg2 = lg2; cfg_thresh = th; cfg_rtt = rtt; xfer_left = xl;
      doorbell = 1'b0; cmd_ready = 1'b1; resp_en = 1'b1; resp_lat = 4;
      for (int i = 0; i < 16; i++) host_mem[i] = '0;
      wait_cyc(3);
      rst_n = 1'b1;
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst_n = 1'b0;
      wait_cyc(2);
      check(req_valid == 1'b0, "R1 req_valid in reset", req_valid, 0);
      check(cmd_valid == 1'b0, "R1 cmd_valid in reset", cmd_valid, 0);
   endtask

   task automatic t_cap;
      do_reset(3'd2, 4'd0, 8'd0, 8'd0);
      resp_en = 1'b0;
      wait_cyc(20);
      check(fires == 2, "R3 fires with no answers", fires, 2);
      check(addr_log.size() > 1 && addr_log[0] == BASE, "R2 first address",
            addr_log.size() > 0 ? addr_log[0] : 0, BASE);
      check(addr_log.size() > 1 && addr_log[1] == BASE + 64, "R2 second address",
            addr_log.size() > 1 ? addr_log[1] : 0, BASE + 64);
      resp_en = 1'b1;
      wait_cyc(20);
   endtask

   task automatic t_poll;
      do_reset(3'd2, 4'd0, 8'd0, 8'd0);
      wait_cyc(60);
      check(fires >= 4, "R2 polling continues without doorbell", fires, 4);
      check(len_bad == 0, "R2 request length 64", len_bad, 0);
      check(got.size() == 0, "R4 empty ring yields no command", got.size(), 0);
   endtask

   task automatic t_new_wrap;
      do_reset(3'd2, 4'd0, 8'd0, 8'd0);
      put_entry(0, 1'b1, 32'hA0); put_entry(1, 1'b1, 32'hA1);
      wait_cyc(60);
      check(got.size() == 2, "R4 two new entries", got.size(), 2);
      check(got.size() == 2 && got[0] == 32'hA0 && got[1] == 32'hA1, "R11 order first lap",
            got.size() > 0 ? got[0] : 0, 32'hA0);
      put_entry(2, 1'b1, 32'hA2); put_entry(3, 1'b1, 32'hA3);
      put_entry(0, 1'b0, 32'hB0);
      wait_cyc(100);
      check(got.size() == 5, "R5 second lap stops at stale slot 1", got.size(), 5);
      check(got.size() == 5 && got[4] == 32'hB0, "R5 phase 0 accepted after wrap",
            got.size() == 5 ? got[4] : 0, 32'hB0);
   endtask

   task automatic t_squash;
      do_reset(3'd2, 4'd0, 8'd0, 8'd0);
      put_entry(1, 1'b1, 32'hC1);
      wait_cyc(80);
      check(fires >= 4, "R6 refetch after miss", fires, 4);
      check(got.size() == 0, "R6 entry beyond empty head discarded", got.size(), 0);
      put_entry(0, 1'b1, 32'hC0);
      wait_cyc(60);
      check(got.size() == 2 && got[0] == 32'hC0 && got[1] == 32'hC1, "R6 in-order after fill",
            got.size() > 0 ? got[0] : 0, 32'hC0);
   endtask

   task automatic t_fifo_full;
      int f1;
      do_reset(3'd3, 4'd0, 8'd0, 8'd0);
      for (int i = 0; i < 6; i++) put_entry(i, 1'b1, 32'hD0 + i);
      cmd_ready = 1'b0;
      wait_cyc(80);
      f1 = fires;
      wait_cyc(30);
      check(fires == f1, "R7 no fetch while queue reserved", fires, f1);
      check(cmd_valid == 1'b1 && cmd_data[31:0] == 32'hD0, "R11 held command",
            cmd_data[31:0], 32'hD0);
      cmd_ready = 1'b1;
      wait_cyc(80);
      check(got.size() == 6, "R7 all entries after release", got.size(), 6);
      for (int i = 0; i < 6; i++)
         if (i < got.size())
            check(got[i] == 32'hD0 + i, "R11 ring order", got[i], 32'hD0 + i);
   endtask

   task automatic t_timing;
      do_reset(3'd2, 4'd0, 8'd3, 8'd10);
      wait_cyc(20);
      check(fires == 0, "R8 held while transfer far from end", fires, 0);
      xfer_left = 8'd3;
      wait_cyc(20);
      check(fires > 0, "R8 issued inside lead window", fires, 1);
   endtask

   task automatic t_doorbell;
      do_reset(3'd2, 4'd3, 8'd0, 8'd0);
      wait_cyc(20);
      check(fires == 0, "R9 quiet without doorbell", fires, 0);
      put_entry(0, 1'b1, 32'hE0); put_entry(1, 1'b1, 32'hE1);
      doorbell = 1'b1;
      wait_cyc(1);
      doorbell = 1'b0;
      wait_cyc(60);
      check(fires == 3, "R9 drain run ends at empty slot", fires, 3);
      check(got.size() == 2, "R9 commands from doorbell run", got.size(), 2);
   endtask

   task automatic t_mode_switch;
      int f1;
      do_reset(3'd2, 4'd2, 8'd0, 8'd0);
      put_entry(0, 1'b1, 32'hF0); put_entry(1, 1'b1, 32'hF1);
      doorbell = 1'b1;
      wait_cyc(1);
      doorbell = 1'b0;
      wait_cyc(40);
      check(fires > 3, "R10 polling after load reaches threshold", fires, 4);
      wait_cyc(200);
      f1 = fires;
      wait_cyc(40);
      check(fires == f1, "R10 polling stops when load decays", fires, f1);
   endtask

   task automatic report;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      t_reset;
      t_cap;
      t_poll;
      t_new_wrap;
      t_squash;
      t_fifo_full;
      t_timing;
      t_doorbell;
      t_mode_switch;
      finished = 1'b1;
      report;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         report;
         $finish;
      end
   end
endmodule